// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

The block is a watchdog for a system that must prove it is still alive. Once software turns it on, a counter runs on the watchdog clock. Software has to restart that counter in time by writing a key byte. If the count reaches the programmed timeout, or if software writes the wrong key, the block raises a reset request. That request stays high until the block itself is reset.

An optional window mode splits each period into two phases. The first is a closed phase, during which a restart counts as a fault. The second is an open phase, during which a restart is accepted. A separate early-warning flag can interrupt software a programmable number of cycles after each restart, so that software has a chance to service the watchdog before the timeout. An always-on bit locks the watchdog running until the next reset.

Software reaches the block over a byte-wide synchronous bus. A write takes effect on the clock edge where the write enable is sampled high. Reads are combinational from the address. A busy output models a fixed synchronisation delay after writes that affect the counting domain.

Top module: `wdog_win`

## Requirements
- R1: After reset the following values hold.
  - Offset 0x0 (control) reads 0x00.
  - Offset 0x1 (setup) reads 0xBB.
  - Offset 0x2 (warning offset) reads 0x0B.
  - Offsets 0x4, 0x5 (interrupt enable) and 0x6 (warning flag) read 0x00.
  - Offset 0x7 (status) reads 0x00.
  - rst_req, irq and busy are all low.
- R2: Register fields and widths are as follows.
  - Control: only bit 1 (run), bit 2 (window) and bit 7 (lock) are kept. All other control bits read 0.
  - Setup: all 8 bits are kept, with the timeout code in bits 3:0 and the closed-phase code in bits 7:4.
  - Warning offset: only bits 3:0 are kept.
  - Offsets 0x3 and 0x8 read 0x00.
- R3: A period code c selects 8<<c cycles. Codes above 11 act as 11. Without window mode, rst_req rises exactly 8<<c clock edges after the edge that enabled the counter or that accepted the last restart.
- R4: Writing 0xA5 to offset 0x8 while running, outside the closed phase, restarts the count and does not raise rst_req.
- R5: Writing any byte other than 0xA5 to offset 0x8 while running raises rst_req on that same edge. While not running, such a write has no effect.
- R6: In window mode the closed-phase length is L = 8<<(setup bits 7:4).
  - A 0xA5 write landing N edges after the restart raises rst_req if N ≤ L.
  - For N > L the write restarts the count.
  - The timeout is L plus the timeout-code length.
- R7: The warning flag (offset 0x6, bit 0) is set 8<<e edges after the restart, where e is the warning code. Writing 1 to that bit clears the flag. Writing 0 leaves it unchanged.
- R8: Interrupt enable (bit 0) works as follows.
  - Writing 1 to offset 0x5 sets it.
  - Writing 1 to offset 0x4 clears it.
  - Both offsets read it back.
  - irq is high exactly when the flag and the enable are both set.
- R9: Writing control with bit 7 set locks the block until reset. Control then reads with bits 1, 2 and 7 set, window mode is active, and writes to control and setup are ignored.
- R10: A write to offset 0x0, 0x1 or 0x8 holds busy high for 3 edges, and status bit 7 mirrors busy. Other writes do not start busy.
- R11: Once rst_req is high it stays high until rst_n is asserted.
- R12: While the run bit is clear, the count is held at zero and no timeout occurs. Re-enabling starts a full period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write enable, sampled on the rising edge |
| bus_rdata | output | 8 | Read data for bus_addr |
| rst_req | output | 1 | Sticky system reset request |
| irq | output | 1 | Early-warning interrupt |
| busy | output | 1 | Synchronisation busy indication |

## Verification
The hardest case to reach is the boundary between the closed and open phases of window mode. A restart written on the last closed edge must fault, while a restart one edge later must be accepted. The bench reaches both cases in a sweep over closed and open codes. For each pair it enables the block and waits a computed number of edges, so that the key write lands exactly on edge L or on edge L+1. After an accepted restart it then checks the combined timeout to the exact edge.

// File: rtl/wdog_win.sv
module wdog_win #(
  parameter int SHIFT_BASE  = 3,
  parameter int CODE_MAX    = 11,
  parameter int BUSY_CYCLES = 3,
  parameter logic [7:0] KEY = 8'hA5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] bus_addr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_we,
  output logic [7:0] bus_rdata,
  output logic       rst_req,
  output logic       irq,
  output logic       busy
);
  localparam int LIM_W = SHIFT_BASE + CODE_MAX + 2;
  localparam int BW    = $clog2(BUSY_CYCLES + 1);
  localparam logic [7:0] CTL_KEEP = 8'h86;

  logic [7:0]       ctl_q, cfg_q;
  logic [3:0]       ewo_q;
  logic             ie_q, flag_q;
  logic [BW-1:0]    busy_q;
  logic [LIM_W-1:0] since_q;

  function automatic logic [LIM_W-1:0] code_lim(input logic [3:0] c);
    logic [3:0] cc;
    cc = (int'(c) > CODE_MAX) ? 4'(CODE_MAX) : c;
    return LIM_W'(1) << (SHIFT_BASE + int'(cc));
  endfunction

  wire run  = ctl_q[1];
  wire win  = ctl_q[2];
  wire lock = ctl_q[7];

  wire wr_ctl  = bus_we && bus_addr == 4'h0;
  wire wr_cfg  = bus_we && bus_addr == 4'h1;
  wire wr_ewo  = bus_we && bus_addr == 4'h2;
  wire wr_iclr = bus_we && bus_addr == 4'h4;
  wire wr_iset = bus_we && bus_addr == 4'h5;
  wire wr_flag = bus_we && bus_addr == 4'h6;
  wire wr_kick = bus_we && bus_addr == 4'h8;

  wire key_ok  = wr_kick && bus_wdata == KEY;
  wire key_bad = wr_kick && bus_wdata != KEY;

  wire [LIM_W-1:0] per_lim    = code_lim(cfg_q[3:0]);
  wire [LIM_W-1:0] closed_lim = code_lim(cfg_q[7:4]);
  wire [LIM_W-1:0] ew_lim     = code_lim(ewo_q);
  wire [LIM_W-1:0] tmo_lim    = win ? closed_lim + per_lim : per_lim;

  wire early   = win && (since_q < closed_lim);
  wire expired = since_q == tmo_lim - LIM_W'(1);
  wire fault   = run && (key_bad || (key_ok ? early : expired));
  wire ew_hit  = run && !key_ok && (since_q == ew_lim - LIM_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= 8'h00;
      cfg_q <= 8'hBB;
      ewo_q <= 4'hB;
    end else begin
      if (wr_ctl && !lock)
        ctl_q <= (bus_wdata & CTL_KEEP) | (bus_wdata[7] ? 8'h06 : 8'h00);
      if (wr_cfg && !lock)
        cfg_q <= bus_wdata;
      if (wr_ewo)
        ewo_q <= bus_wdata[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      since_q <= '0;
    else if (!run || key_ok)
      since_q <= '0;
    else if (since_q != '1)
      since_q <= since_q + LIM_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_req <= 1'b0;
    else if (fault)
      rst_req <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_iset && bus_wdata[0])
        ie_q <= 1'b1;
      else if (wr_iclr && bus_wdata[0])
        ie_q <= 1'b0;
      if (ew_hit)
        flag_q <= 1'b1;
      else if (wr_flag && bus_wdata[0])
        flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      busy_q <= '0;
    else if (wr_ctl || wr_cfg || wr_kick)
      busy_q <= BW'(BUSY_CYCLES);
    else if (busy_q != '0)
      busy_q <= busy_q - BW'(1);
  end

  assign busy = busy_q != '0;
  assign irq  = flag_q & ie_q;

  always_comb begin
    case (bus_addr)
      4'h0:    bus_rdata = ctl_q;
      4'h1:    bus_rdata = cfg_q;
      4'h2:    bus_rdata = {4'h0, ewo_q};
      4'h4,
      4'h5:    bus_rdata = {7'h0, ie_q};
      4'h6:    bus_rdata = {7'h0, flag_q};
      4'h7:    bus_rdata = {busy, 7'h0};
      default: bus_rdata = 8'h00;
    endcase
  end

  AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n) rst_req |=> rst_req); // R11
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n) lock |=> lock); // R9
  AST_LOCK_FORCES_RUN: assert property (@(posedge clk) disable iff (!rst_n) lock |-> (run && win)); // R9
  AST_BAD_KEY_RESET: assert property (@(posedge clk) disable iff (!rst_n) (key_bad && run) |=> rst_req); // R5
  AST_EARLY_KICK: assert property (@(posedge clk) disable iff (!rst_n) (key_ok && run && win && since_q < closed_lim) |=> rst_req); // R6
  AST_IDLE_HELD: assert property (@(posedge clk) disable iff (!rst_n) !run |=> since_q == '0); // R12
  AST_BUSY_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n) (wr_ctl || wr_cfg || wr_kick) |=> busy); // R10
endmodule

// File: tb/wdog_win_bench.sv
module wdog_win_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [7:0] bus_wdata = 8'h00;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic       rst_req, irq, busy;
  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  wdog_win u_wdog_win (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .rst_req(rst_req), .irq(irq), .busy(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    bus_addr = a;
    #1;
    v = int'(bus_rdata);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_we = 1'b0;
    step(2);
    rst_n = 1'b1;
  endtask

  task automatic run_tests();
    int v;
    int lim, cl, op;
    do_reset();
    // R1 reset state
    rd(4'h0, v); check("R1 ctl", v, 8'h00);
    rd(4'h1, v); check("R1 setup", v, 8'hBB);
    rd(4'h2, v); check("R1 warn", v, 8'h0B);
    rd(4'h4, v); check("R1 ie", v, 0);
    rd(4'h6, v); check("R1 flag", v, 0);
    rd(4'h7, v); check("R1 status", v, 0);
    check("R1 outputs", {rst_req, irq, busy}, 0);
    // R2 field masks
    wr(4'h0, 8'h79); rd(4'h0, v); check("R2 ctl reserved", v, 8'h00);
    wr(4'h0, 8'h7D); rd(4'h0, v); check("R2 ctl window", v, 8'h04);
    wr(4'h0, 8'h00);
    wr(4'h1, 8'h5A); rd(4'h1, v); check("R2 setup", v, 8'h5A);
    wr(4'h2, 8'hF3); rd(4'h2, v); check("R2 warn", v, 8'h03);
    rd(4'h3, v); check("R2 hole", v, 0);
    rd(4'h8, v); check("R2 kick read", v, 0);
    // R3 timeout sweep, codes 0..12 (12 clamps to 11)
    for (int c = 0; c <= 12; c++) begin
      do_reset();
      lim = 8 << ((c > 11) ? 11 : c);
      wr(4'h1, {4'hB, 4'(c)});
      wr(4'h0, 8'h02);
      step(lim - 1); check($sformatf("R3 code %0d before", c), rst_req, 0);
      step(1);       check($sformatf("R3 code %0d at", c), rst_req, 1);
      if (c == 0) begin
        step(10); check("R11 sticky", rst_req, 1);
      end
    end
    // R4 periodic restarts
    do_reset();
    wr(4'h1, 8'h02); wr(4'h0, 8'h02);
    for (int k = 0; k < 5; k++) begin
      step(19); wr(4'h8, 8'hA5);
      check("R4 kick keeps alive", rst_req, 0);
    end
    step(31); check("R4 after last kick", rst_req, 0);
    step(1);  check("R4 timeout from kick", rst_req, 1);
    // R5 wrong key
    do_reset();
    wr(4'h1, 8'h05); wr(4'h0, 8'h02); step(3);
    wr(4'h8, 8'h5A); check("R5 bad key running", rst_req, 1);
    do_reset();
    wr(4'h1, 8'h00); wr(4'h8, 8'h00);
    check("R5 bad key idle", rst_req, 0);
    step(50); check("R12 idle no timeout", rst_req, 0);
    // R6 window sweep
    for (int w = 0; w < 3; w++) begin
      for (int p = 0; p < 3; p++) begin
        cl = 8 << w; op = 8 << p;
        do_reset();
        wr(4'h1, {4'(w), 4'(p)}); wr(4'h0, 8'h06);
        step(cl - 1); wr(4'h8, 8'hA5);
        check($sformatf("R6 w%0d p%0d last closed edge", w, p), rst_req, 1);
        do_reset();
        wr(4'h1, {4'(w), 4'(p)}); wr(4'h0, 8'h06);
        step(cl); wr(4'h8, 8'hA5);
        check($sformatf("R6 w%0d p%0d first open edge", w, p), rst_req, 0);
        step(cl + op - 1);
        check($sformatf("R6 w%0d p%0d before timeout", w, p), rst_req, 0);
        step(1);
        check($sformatf("R6 w%0d p%0d timeout", w, p), rst_req, 1);
      end
    end
    // R7 / R8 early warning
    do_reset();
    wr(4'h1, 8'h03); wr(4'h2, 8'h01); wr(4'h0, 8'h02);
    step(15); rd(4'h6, v); check("R7 flag early", v, 0);
    step(1);  rd(4'h6, v); check("R7 flag set", v, 1);
    check("R8 irq masked", irq, 0);
    wr(4'h6, 8'h00); rd(4'h6, v); check("R7 write 0 keeps", v, 1);
    wr(4'h6, 8'h01); rd(4'h6, v); check("R7 w1c", v, 0);
    wr(4'h5, 8'h01); rd(4'h4, v); check("R8 enable via clr addr", v, 1);
    rd(4'h5, v); check("R8 enable via set addr", v, 1);
    check("R8 irq no flag", irq, 0);
    wr(4'h8, 8'hA5); step(15); check("R8 irq before", irq, 0);
    step(1); check("R8 irq fires", irq, 1);
    wr(4'h4, 8'h01); check("R8 irq off", irq, 0);
    rd(4'h5, v); check("R8 enable cleared", v, 0);
    check("R7 no reset", rst_req, 0);
    // R9 lock
    do_reset();
    wr(4'h1, 8'h10); wr(4'h0, 8'h80);
    rd(4'h0, v); check("R9 lock forces", v, 8'h86);
    wr(4'h0, 8'h00); rd(4'h0, v); check("R9 ctl frozen", v, 8'h86);
    wr(4'h1, 8'h33); rd(4'h1, v); check("R9 setup frozen", v, 8'h10);
    check("R9 no reset yet", rst_req, 0);
    wr(4'h8, 8'hA5); check("R9 window forced", rst_req, 1);
    // R10 busy
    do_reset();
    wr(4'h1, 8'hBB); check("R10 busy set", busy, 1);
    rd(4'h7, v); check("R10 status", v, 8'h80);
    step(2); check("R10 busy held", busy, 1);
    step(1); check("R10 busy done", busy, 0);
    rd(4'h7, v); check("R10 status clear", v, 0);
    wr(4'h2, 8'h03); check("R10 other write", busy, 0);
    wr(4'h8, 8'hA5); check("R10 kick busy", busy, 1);
    // R12 disable then re-enable
    do_reset();
    wr(4'h1, 8'h00); wr(4'h0, 8'h02); step(5);
    wr(4'h0, 8'h00); step(30); check("R12 disabled", rst_req, 0);
    wr(4'h0, 8'h02); step(7); check("R12 fresh period", rst_req, 0);
    step(1); check("R12 timeout", rst_req, 1);
  endtask

  initial begin
    fork
      run_tests();
      begin
        #(4 * 180000);
        nchk++; nfail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule